// File: doc/BRIEF.md
# Packet Buffer Page Manager

This block owns a pool of fixed-size buffer pages for a small network controller. A host drives it through a narrow register port. It writes a 3-bit opcode into a command strobe, loads a selected packet number, and reads back a status word. The opcodes let the host claim a page, hand a page back, queue a packet for sending, and retire packets after sending. Page ownership is kept in a used-page bitmap. A claim always returns the lowest-numbered free page.

Two queues hold packet numbers. The send queue holds packets waiting for the transmitter. The done queue holds packets the transmitter has finished with. A one-cycle `xmit_done` strobe from the transmit side moves the head of the send queue into the done queue. Claims take one extra cycle to resolve. Page returns keep a busy flag raised for a fixed number of cycles. While either of these is in progress, any new command is refused and a sticky protocol-error flag is raised.

Top module: `pbm_mgr`

## Requirements
- R1: After reset: `pnr_q`=0, `arr_q`=0, `busy`=0, `alloc_done`=0, `proto_err`=0, `free_pages`=NPAGES (64), and both queues are empty.
- R2: Claim (opcode 1). In the cycle after an accepted write, `arr_q[7]` (failed) reads 1. One cycle later, `arr_q` = {0, 0, page} with page in bits 5:0, page is the lowest free index, and `alloc_done` is high for exactly one cycle.
- R3: A claim made when no page is free leaves `arr_q`=8'h80 (failed set, page field 0). `alloc_done` still pulses.
- R4: Return by number (opcode 5) frees the page held in `pnr_q[5:0]`. `busy` is high for exactly REL_CYCLES (4) cycles, starting the cycle after the write. `free_pages` does not change while `busy` is high and rises by one when `busy` falls.
- R5: A return of a page that is not in use runs the same `busy` window. It leaves `free_pages` unchanged and sets `proto_err`.
- R6: A command written while `busy` is high, or while a claim is still pending, has no effect and sets `proto_err`. `proto_err` stays set until reset.
- R7: Opcode 6 appends `pnr_q[5:0]` to the send queue. `xmit_done` moves the head of the send queue to the tail of the done queue. Both queues are first-in first-out.
- R8: Opcode 3 drops the head of the done queue without freeing its page. Opcode 4 drops that head and returns its page, with the same `busy` timing as R4.
- R9: Opcode 7 empties both queues and leaves `free_pages` unchanged.
- R10: Opcode 2 marks every page free, clears `pnr_q` and both queues, and leaves `arr_q` unchanged.
- R11: `pnr_q` holds a 6-bit number in bits 5:0, and bits 7:6 read 0. A write to it while `busy` is high is dropped and sets `proto_err`.
- R12: Opcode 3 or 4 with an empty done queue changes nothing, does not raise `busy`, and sets `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 3 | Command opcode |
| pnr_wr | input | 1 | Packet-number register write strobe |
| pnr_wdata | input | 6 | Packet number to write |
| xmit_done | input | 1 | Transmitter finished the head of the send queue |
| pnr_q | output | 8 | Packet-number register readback |
| arr_q | output | 8 | Claim result: bit 7 failed, bits 5:0 page |
| alloc_done | output | 1 | One-cycle pulse when a claim resolves |
| busy | output | 1 | A page return is in progress |
| proto_err | output | 1 | Sticky protocol-error flag |
| tx_head | output | 6 | Head of the send queue |
| tx_empty | output | 1 | Send queue empty |
| cmp_head | output | 6 | Head of the done queue |
| cmp_empty | output | 1 | Done queue empty |
| free_pages | output | 7 | Number of free pages |

## Verification
Bitmap faults show up at the ports within two cycles of the next claim: the granted page in `arr_q` is not the lowest free index, or `free_pages` drifts from the count the bench keeps. A fault in the return counter appears as a `busy` window of the wrong length. It can also appear as a page count that changes while `busy` is still high. Queue pointer faults show as a wrong `tx_head` or `cmp_head` on the very next readback after a push, move or drop. A wrong acceptance rule shows as `proto_err` staying low, or a page count that moves, in the cycle after a refused command.

// File: rtl/pbm_pkg.sv
`timescale 1ns/1ps
package pbm_pkg;
  localparam logic [2:0] OP_ALLOC    = 3'd1;
  localparam logic [2:0] OP_MMU_RST  = 3'd2;
  localparam logic [2:0] OP_CMP_DROP = 3'd3;
  localparam logic [2:0] OP_CMP_FREE = 3'd4;
  localparam logic [2:0] OP_PNR_FREE = 3'd5;
  localparam logic [2:0] OP_TX_ENQ   = 3'd6;
  localparam logic [2:0] OP_TXQ_CLR  = 3'd7;
endpackage

// File: rtl/pbm_pagemap.sv
`timescale 1ns/1ps
module pbm_pagemap #(
  parameter int NPAGES = 64,
  localparam int IW = $clog2(NPAGES),
  localparam int FW = $clog2(NPAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              set_en,
  input  logic [IW-1:0]     set_idx,
  input  logic              rel_en,
  input  logic [IW-1:0]     rel_idx,
  output logic [NPAGES-1:0] used_o,
  output logic              free_found,
  output logic [IW-1:0]     free_idx,
  output logic [FW-1:0]     free_cnt
);
  logic [NPAGES-1:0] used_q;

  // {found, index} of the lowest clear bit
  function automatic logic [IW:0] first_free(input logic [NPAGES-1:0] m);
    logic [IW:0] r;
    r = '0;
    for (int i = NPAGES - 1; i >= 0; i--)
      if (!m[i]) r = {1'b1, IW'(i)};
    return r;
  endfunction

  function automatic logic [FW-1:0] count_free(input logic [NPAGES-1:0] m);
    logic [FW-1:0] c;
    c = '0;
    for (int i = 0; i < NPAGES; i++) c = c + FW'(!m[i]);
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) used_q <= '0;
    else begin
      if (set_en) used_q[set_idx] <= 1'b1;
      if (rel_en) used_q[rel_idx] <= 1'b0;
    end
  end

  assign {free_found, free_idx} = first_free(used_q);
  assign free_cnt = count_free(used_q);
  assign used_o   = used_q;
endmodule

// File: rtl/pbm_fifo.sv
`timescale 1ns/1ps
module pbm_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop) cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && rst_n && !clr) mem[wp] <= din;
  end
endmodule

// File: rtl/pbm_mgr.sv
`timescale 1ns/1ps
module pbm_mgr #(
  parameter int NPAGES     = 64,
  parameter int QDEPTH     = 8,
  parameter int REL_CYCLES = 4,
  localparam int PW = $clog2(NPAGES),
  localparam int FW = $clog2(NPAGES + 1),
  localparam int CW = $clog2(REL_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [2:0]    cmd_op,
  input  logic          pnr_wr,
  input  logic [PW-1:0] pnr_wdata,
  input  logic          xmit_done,
  output logic [7:0]    pnr_q,
  output logic [7:0]    arr_q,
  output logic          alloc_done,
  output logic          busy,
  output logic          proto_err,
  output logic [PW-1:0] tx_head,
  output logic          tx_empty,
  output logic [PW-1:0] cmp_head,
  output logic          cmp_empty,
  output logic [FW-1:0] free_pages
);
  import pbm_pkg::*;

  logic [PW-1:0]     pnr;
  logic              arr_failed;
  logic [PW-1:0]     arr_page;
  logic              alloc_pend;
  logic [CW-1:0]     rel_cnt;
  logic [PW-1:0]     rel_idx_q;
  logic              rel_ok_q;
  logic [NPAGES-1:0] used_map;
  logic              free_found;
  logic [PW-1:0]     free_idx;
  logic              tx_full, cmp_full;

  // named internal events
  logic          ev_accept, ev_reject, ev_alloc_start, ev_alloc_end;
  logic          ev_rel_start, ev_rel_end, ev_cmp_underrun, ev_enq_full;
  logic          ev_rel_unused, ev_pnr_blocked, ev_err, ev_qclear, ev_mmu_rst;
  logic          ev_tx_move, ev_cmp_pop;
  logic [PW-1:0] rel_pkt;

  assign busy            = (rel_cnt != '0);
  assign ev_accept       = cmd_wr && !busy && !alloc_pend;
  assign ev_reject       = cmd_wr && !ev_accept;
  assign ev_alloc_start  = ev_accept && (cmd_op == OP_ALLOC);
  assign ev_alloc_end    = alloc_pend;
  assign ev_mmu_rst      = ev_accept && (cmd_op == OP_MMU_RST);
  assign ev_qclear       = ev_mmu_rst || (ev_accept && (cmd_op == OP_TXQ_CLR));
  assign ev_cmp_pop      = ev_accept && ((cmd_op == OP_CMP_DROP) || (cmd_op == OP_CMP_FREE));
  assign ev_cmp_underrun = ev_cmp_pop && cmp_empty;
  assign ev_enq_full     = ev_accept && (cmd_op == OP_TX_ENQ) && tx_full;
  assign rel_pkt         = (cmd_op == OP_PNR_FREE) ? pnr : cmp_head;
  assign ev_rel_start    = ev_accept && ((cmd_op == OP_PNR_FREE) ||
                                         ((cmd_op == OP_CMP_FREE) && !cmp_empty));
  assign ev_rel_unused   = ev_rel_start && !used_map[rel_pkt];
  assign ev_rel_end      = (rel_cnt == CW'(1));
  assign ev_pnr_blocked  = pnr_wr && busy;
  assign ev_err          = ev_reject || ev_cmp_underrun || ev_enq_full ||
                           ev_rel_unused || ev_pnr_blocked;
  assign ev_tx_move      = xmit_done && !tx_empty && !cmp_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pnr <= '0; arr_failed <= 1'b0; arr_page <= '0; alloc_pend <= 1'b0;
      alloc_done <= 1'b0; rel_cnt <= '0; rel_idx_q <= '0; rel_ok_q <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      alloc_pend <= ev_alloc_start;
      alloc_done <= ev_alloc_end;
      if (ev_err) proto_err <= 1'b1;
      if (ev_mmu_rst) pnr <= '0;
      else if (pnr_wr && !busy) pnr <= pnr_wdata;
      if (ev_alloc_start) arr_failed <= 1'b1;
      else if (ev_alloc_end) begin
        arr_failed <= !free_found;
        arr_page   <= free_found ? free_idx : '0;
      end
      if (ev_rel_start) begin
        rel_cnt   <= CW'(REL_CYCLES);
        rel_idx_q <= rel_pkt;
        rel_ok_q  <= used_map[rel_pkt];
      end else if (busy) rel_cnt <= rel_cnt - 1'b1;
    end
  end

  pbm_pagemap #(.NPAGES(NPAGES)) map_i (
    .clk(clk), .rst_n(rst_n), .clr_all(ev_mmu_rst),
    .set_en(ev_alloc_end && free_found), .set_idx(free_idx),
    .rel_en(ev_rel_end && rel_ok_q), .rel_idx(rel_idx_q),
    .used_o(used_map), .free_found(free_found), .free_idx(free_idx),
    .free_cnt(free_pages)
  );

  pbm_fifo #(.W(PW), .DEPTH(QDEPTH)) txq_i (
    .clk(clk), .rst_n(rst_n), .clr(ev_qclear),
    .push(ev_accept && (cmd_op == OP_TX_ENQ)), .din(pnr),
    .pop(ev_tx_move), .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  pbm_fifo #(.W(PW), .DEPTH(QDEPTH)) cmpq_i (
    .clk(clk), .rst_n(rst_n), .clr(ev_qclear),
    .push(ev_tx_move), .din(tx_head),
    .pop(ev_cmp_pop), .dout(cmp_head), .empty(cmp_empty), .full(cmp_full)
  );

  assign pnr_q = 8'(pnr);
  assign arr_q = {arr_failed, 7'(arr_page)};
endmodule

// File: rtl/pbm_mgr_chk.sv
`timescale 1ns/1ps
module pbm_mgr_chk #(
  parameter int REL_CYCLES = 4,
  parameter int FW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr,
  input logic [2:0]    cmd_op,
  input logic          busy,
  input logic          alloc_pend,
  input logic          alloc_done,
  input logic [7:0]    arr_q,
  input logic [7:0]    pnr_q,
  input logic          proto_err,
  input logic          tx_empty,
  input logic          cmp_empty,
  input logic [FW-1:0] free_pages
);
  logic [7:0] busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (busy_run == 8'(REL_CYCLES))); // R4
  AST_PAGES_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(free_pages)); // R4
  AST_FAILED_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_wr && cmd_op == 3'd1 && !busy && !alloc_pend) |-> arr_q[7]); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |=> !alloc_done); // R2
  AST_FAIL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> (arr_q[7] == ($past(free_pages) == '0))); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(proto_err) |-> proto_err); // R6
  AST_QCLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_wr && cmd_op == 3'd7 && !busy && !alloc_pend) |-> (tx_empty && cmp_empty)); // R9
  AST_PNR_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    pnr_q[7:6] == 2'b00); // R11
endmodule

bind pbm_mgr pbm_mgr_chk #(.REL_CYCLES(REL_CYCLES), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .busy(busy),
  .alloc_pend(alloc_pend), .alloc_done(alloc_done), .arr_q(arr_q),
  .pnr_q(pnr_q), .proto_err(proto_err), .tx_empty(tx_empty),
  .cmp_empty(cmp_empty), .free_pages(free_pages)
);

// File: tb/pbm_mgr_tb_top.sv
`timescale 1ns/1ps
module pbm_mgr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic       pnr_wr = 1'b0;
  logic [5:0] pnr_wdata = 6'd0;
  logic       xmit_done = 1'b0;
  logic [7:0] pnr_q, arr_q;
  logic       alloc_done, busy, proto_err, tx_empty, cmp_empty;
  logic [5:0] tx_head, cmp_head;
  logic [6:0] free_pages;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk; // 50 MHz

  pbm_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .pnr_wr(pnr_wr), .pnr_wdata(pnr_wdata), .xmit_done(xmit_done),
    .pnr_q(pnr_q), .arr_q(arr_q), .alloc_done(alloc_done), .busy(busy),
    .proto_err(proto_err), .tx_head(tx_head), .tx_empty(tx_empty),
    .cmp_head(cmp_head), .cmp_empty(cmp_empty), .free_pages(free_pages)
  );

  // vector: {op[2:0], arg[5:0], expect[7:0]}
  // op 1: expect = arr_q after claim; op 5: arg = page, expect = free_pages after
  localparam int NV = 9;
  localparam logic [16:0] VEC [NV] = '{
    {3'd1, 6'd0, 8'h00}, {3'd1, 6'd0, 8'h01}, {3'd1, 6'd0, 8'h02},
    {3'd1, 6'd0, 8'h03}, {3'd5, 6'd1, 8'd61}, {3'd5, 6'd2, 8'd62},
    {3'd1, 6'd0, 8'h01}, {3'd1, 6'd0, 8'h02}, {3'd1, 6'd0, 8'h04}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cmd(input logic [2:0] op);
    @(negedge clk); cmd_wr = 1'b1; cmd_op = op;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic set_pnr(input logic [5:0] v);
    @(negedge clk); pnr_wr = 1'b1; pnr_wdata = v;
    @(negedge clk); pnr_wr = 1'b0;
  endtask

  task automatic xmit();
    @(negedge clk); xmit_done = 1'b1;
    @(negedge clk); xmit_done = 1'b0;
  endtask

  task automatic claim(output logic [7:0] res, output logic done);
    cmd(3'd1);
    @(negedge clk);
    res = arr_q; done = alloc_done;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic d;
    int n;
    hw_reset();
    @(negedge clk);
    check("R1 pnr", pnr_q, 0);
    check("R1 arr", arr_q, 0);
    check("R1 busy", busy, 0);
    check("R1 err", proto_err, 0);
    check("R1 free", free_pages, 64);
    check("R1 queues", {tx_empty, cmp_empty}, 3);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16:14] == 3'd1) begin
        cmd(3'd1);
        check("R2 failed-while-pending", arr_q[7], 1);
        @(negedge clk);
        check("R2 page", arr_q, VEC[i][7:0]);
        check("R2 done", alloc_done, 1);
        @(negedge clk);
        check("R2 done one cycle", alloc_done, 0);
      end else begin
        set_pnr(VEC[i][13:8]);
        cmd(3'd5);
        check("R4 held", free_pages, VEC[i][7:0] - 1);
        busy_len(n);
        check("R4 busy len", n, 4);
        check("R4 freed", free_pages, VEC[i][7:0]);
      end
    end
    check("R6 no error yet", proto_err, 0);

    // R7 queue order
    set_pnr(6'd3); cmd(3'd6);
    set_pnr(6'd4); cmd(3'd6);
    check("R7 tx head", tx_head, 3);
    xmit();
    check("R7 cmp head", cmp_head, 3);
    check("R7 tx head next", tx_head, 4);
    xmit();
    check("R7 tx empty", tx_empty, 1);
    // R8 drop and drop+free
    cmd(3'd3);
    check("R8 drop head", cmp_head, 4);
    check("R8 drop no free", free_pages, 59);
    check("R8 drop no busy", busy, 0);
    cmd(3'd4);
    busy_len(n);
    check("R8 free busy len", n, 4);
    check("R8 freed", free_pages, 60);
    check("R8 cmp empty", cmp_empty, 1);
    claim(r, d);
    check("R8 reclaimed page", r, 8'h04);
    // R9
    set_pnr(6'd0); cmd(3'd6);
    set_pnr(6'd1); cmd(3'd6);
    xmit();
    cmd(3'd7);
    check("R9 queues empty", {tx_empty, cmp_empty}, 3);
    check("R9 pages kept", free_pages, 59);
    check("R9 no error", proto_err, 0);
    // R10
    set_pnr(6'd9);
    check("R11 pnr value", pnr_q, 9);
    cmd(3'd2);
    check("R10 pnr cleared", pnr_q, 0);
    check("R10 all free", free_pages, 64);
    check("R10 arr kept", arr_q, 8'h04);
    // R3 exhaustion
    for (int k = 0; k < 64; k++) claim(r, d);
    check("R3 last page", r, 63);
    claim(r, d);
    check("R3 failed arr", r, 8'h80);
    check("R3 done pulse", d, 1);
    check("R3 free zero", free_pages, 0);
    check("R3 no error", proto_err, 0);

    // R12
    hw_reset();
    cmd(3'd3);
    check("R12 busy", busy, 0);
    check("R12 err", proto_err, 1);
    // R6 command while busy
    hw_reset();
    claim(r, d);
    set_pnr(6'd0);
    cmd(3'd5);
    cmd(3'd1);
    busy_len(n);
    @(negedge clk);
    check("R6 claim ignored while busy", free_pages, 64);
    check("R6 err busy", proto_err, 1);
    // R6 command while claim pending
    hw_reset();
    @(negedge clk); cmd_wr = 1'b1; cmd_op = 3'd1;
    @(negedge clk); cmd_wr = 1'b1; cmd_op = 3'd1;
    @(negedge clk); cmd_wr = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 second claim ignored", free_pages, 63);
    check("R6 err pending", proto_err, 1);
    // R11 pnr write while busy
    hw_reset();
    claim(r, d);
    set_pnr(6'd0);
    cmd(3'd5);
    set_pnr(6'd7);
    check("R11 pnr held", pnr_q, 0);
    busy_len(n);
    check("R11 err", proto_err, 1);
    check("R11 release done", free_pages, 64);
    // R5 release of unused page
    hw_reset();
    set_pnr(6'd10);
    cmd(3'd5);
    check("R5 busy", busy, 1);
    busy_len(n);
    check("R5 busy len", n, 4);
    check("R5 free unchanged", free_pages, 64);
    check("R5 err", proto_err, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule